// File: doc/BRIEF.md
# Command-to-Data Latency Window Timer

This block sits beside the command path of a DDR3-style memory controller or device model. Each accepted read or write command starts a private countdown. When the countdown reaches the command's latency, the block raises a read or write data-window enable. The enable stays high for as many clocks as the burst takes. Read latency is the additive latency plus the CAS latency. Write latency is the additive latency plus the CAS write latency. The additive latency is not given in clocks: it is chosen by a two-bit code relative to the CAS latency.

Several commands may be in flight at once, each in its own tracking slot, so windows that meet or overlap come out as one continuous enable. The latency settings are taken from the live inputs only while nothing is pending. Once a command is outstanding, a held copy is used until every slot has drained, so a mid-flight change cannot move a window that is already scheduled. A reserved additive code or an out-of-range latency raises an error flag, and any command offered during that time is discarded.

Top module: `lat_window_timer`

## Requirements
- R1: After reset both window enables are low and no command is pending.
- R2: A read command sampled at clock edge n raises `rd_win` in the cycle that follows edge n+AL+CL, where CL is `cas_lat`.
- R3: A write command sampled at edge n raises `wr_win` in the cycle that follows edge n+AL+CWL, where CWL is `cas_wr_lat`.
- R4: `al_code` selects the additive latency: 2'b00 gives 0, 2'b01 gives CL-1, and 2'b10 gives CL-2.
- R5: A window lasts 4 clocks when `cmd_bl8`=1 (burst of 8) and 2 clocks when `cmd_bl8`=0 (burst of 4).
- R6: Up to NSLOT commands, each at least 4 clocks after the previous one, are tracked independently. The windows of one type are OR-combined into a single enable.
- R7: The latency settings follow the inputs only while no command is pending. A change made while commands are pending has no effect until they have all drained.
- R8: `cfg_err` is high when the settings in force have `al_code`=2'b11, CL outside 5..11, or CWL outside 5..8. A command offered while `cfg_err` is high produces no window.
- R9: A read command never raises `wr_win`, and a write command never raises `rd_win`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_vld | input | 1 | Command present this cycle |
| cmd_is_wr | input | 1 | 1 = write, 0 = read |
| cmd_bl8 | input | 1 | 1 = burst of 8, 0 = burst of 4 |
| cas_lat | input | 4 | CAS latency in clocks |
| cas_wr_lat | input | 4 | CAS write latency in clocks |
| al_code | input | 2 | Additive latency select |
| rd_win | output | 1 | Read data window enable |
| wr_win | output | 1 | Write data window enable |
| cfg_err | output | 1 | Settings in force are invalid |

## Verification
Directed cases try the shortest latency, each additive code with the largest CAS latency, and both burst sizes. These separate an off-by-one in the countdown from a wrong additive mapping or a wrong window length. Back-to-back reads 4 clocks apart, and reads overlapping writes, show whether slots interfere with one another and whether the read and write paths stay separate. A setting change made right after a command separates the held settings from the live ones. A long random run then changes settings at arbitrary times, occasionally to invalid values, and compares every cycle of both enables and the error flag against a timeline the bench computes.

// File: rtl/lat_window_timer.sv
module lat_window_timer #(
  parameter int NSLOT   = 8,
  parameter int CLW     = 4,
  parameter int CL_MIN  = 5,
  parameter int CL_MAX  = 11,
  parameter int CWL_MIN = 5,
  parameter int CWL_MAX = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_vld,
  input  logic           cmd_is_wr,
  input  logic           cmd_bl8,
  input  logic [CLW-1:0] cas_lat,
  input  logic [CLW-1:0] cas_wr_lat,
  input  logic [1:0]     al_code,
  output logic           rd_win,
  output logic           wr_win,
  output logic           cfg_err
);
  localparam int TMAX = 2 * CL_MAX + 2;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int IW   = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  logic [NSLOT-1:0] v, is_wr, bl8;
  logic [TW-1:0]    cnt [NSLOT];
  logic [CLW-1:0]   sh_cl, sh_cwl;
  logic [1:0]       sh_al;

  logic             busy;
  logic [CLW-1:0]   eff_cl, eff_cwl;
  logic [1:0]       eff_al;
  logic [TW-1:0]    al_v, lat, tot;
  logic [IW-1:0]    fidx;
  logic             have_free, take;

  assign busy    = |v;
  assign eff_cl  = busy ? sh_cl  : cas_lat;
  assign eff_cwl = busy ? sh_cwl : cas_wr_lat;
  assign eff_al  = busy ? sh_al  : al_code;

  assign cfg_err = (eff_al == 2'b11) ||
                   (int'(eff_cl)  < CL_MIN)  || (int'(eff_cl)  > CL_MAX) ||
                   (int'(eff_cwl) < CWL_MIN) || (int'(eff_cwl) > CWL_MAX);

  always_comb begin
    case (eff_al)
      2'b01:   al_v = TW'(eff_cl) - TW'(1);
      2'b10:   al_v = TW'(eff_cl) - TW'(2);
      default: al_v = '0;
    endcase
  end

  assign lat = al_v + (cmd_is_wr ? TW'(eff_cwl) : TW'(eff_cl));
  assign tot = lat + (cmd_bl8 ? TW'(3) : TW'(1));

  always_comb begin
    have_free = 1'b0;
    fidx      = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (!v[i]) begin
        have_free = 1'b1;
        fidx      = IW'(i);
      end
    end
  end

  assign take = cmd_vld && !cfg_err && have_free;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v      <= '0;
      is_wr  <= '0;
      bl8    <= '0;
      sh_cl  <= '0;
      sh_cwl <= '0;
      sh_al  <= '0;
      for (int i = 0; i < NSLOT; i++) cnt[i] <= '0;
    end else begin
      sh_cl  <= eff_cl;
      sh_cwl <= eff_cwl;
      sh_al  <= eff_al;
      for (int i = 0; i < NSLOT; i++) begin
        if (take && fidx == IW'(i)) begin
          v[i]     <= 1'b1;
          is_wr[i] <= cmd_is_wr;
          bl8[i]   <= cmd_bl8;
          cnt[i]   <= tot;
        end else if (v[i]) begin
          if (cnt[i] == '0) v[i] <= 1'b0;
          else              cnt[i] <= cnt[i] - TW'(1);
        end
      end
    end
  end

  always_comb begin
    rd_win = 1'b0;
    wr_win = 1'b0;
    for (int i = 0; i < NSLOT; i++) begin
      if (v[i] && cnt[i] < (bl8[i] ? TW'(4) : TW'(2))) begin
        if (is_wr[i]) wr_win = 1'b1;
        else          rd_win = 1'b1;
      end
    end
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && !cfg_err) |-> (v != '1));

  // R6
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && !cfg_err) |=> ($countones(v) >= 1));

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (eff_cl == $past(eff_cl) && eff_cwl == $past(eff_cwl) && eff_al == $past(eff_al)));

  // R8
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cfg_err) |=> ($countones(v) <= $past($countones(v))));
endmodule

// File: tb/lat_window_timer_test.sv
module lat_window_timer_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cmd_vld, cmd_is_wr, cmd_bl8;
  logic [3:0] cas_lat, cas_wr_lat;
  logic [1:0] al_code;
  logic rd_win, wr_win, cfg_err;

  lat_window_timer uut (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_is_wr(cmd_is_wr),
    .cmd_bl8(cmd_bl8), .cas_lat(cas_lat), .cas_wr_lat(cas_wr_lat),
    .al_code(al_code), .rd_win(rd_win), .wr_win(wr_win), .cfg_err(cfg_err)
  );

  int checks = 0, fails = 0, cyc = 0, last_end = -1;
  int sh_cl = 0, sh_cwl = 0, sh_al = 0;
  bit exp_rd [64];
  bit exp_wr [64];
  bit done = 0;
  string ph = "R1";

  function automatic int al_of(int code, int cl);
    if (code == 1) return cl - 1;
    if (code == 2) return cl - 2;
    return 0;
  endfunction

  function automatic bit bad_cfg(int cl, int cwl, int al);
    return (al == 3) || cl < 5 || cl > 11 || cwl < 5 || cwl > 8;
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cyc=%0d actual=%0b expected=%0b", req, cyc, act, exp);
    end
  endtask

  task automatic setcfg(int cl, int cwl, int al);
    cas_lat = 4'(cl); cas_wr_lat = 4'(cwl); al_code = 2'(al);
  endtask

  task automatic step(bit cv, bit wr, bit b8);
    int ecl, ecwl, eal, lat, w;
    bit busy, err;
    cmd_vld = cv; cmd_is_wr = wr; cmd_bl8 = b8;
    #1;
    busy = (cyc <= last_end);
    ecl  = busy ? sh_cl  : int'(cas_lat);
    ecwl = busy ? sh_cwl : int'(cas_wr_lat);
    eal  = busy ? sh_al  : int'(al_code);
    err  = bad_cfg(ecl, ecwl, eal);
    check({ph, " R8 cfg_err"}, cfg_err, err);
    @(posedge clk);
    cyc++;
    sh_cl = ecl; sh_cwl = ecwl; sh_al = eal;
    if (cv && !err) begin
      lat = al_of(eal, ecl) + (wr ? ecwl : ecl);
      w   = b8 ? 4 : 2;
      for (int k = 0; k < w; k++) begin
        if (wr) exp_wr[(cyc + lat + k) % 64] = 1'b1;
        else    exp_rd[(cyc + lat + k) % 64] = 1'b1;
      end
      if (cyc + lat + w - 1 > last_end) last_end = cyc + lat + w - 1;
    end
    @(negedge clk);
    check({ph, " R2 R5 R6 R9 rd_win"}, rd_win, exp_rd[cyc % 64]);
    check({ph, " R3 R5 R6 R9 wr_win"}, wr_win, exp_wr[cyc % 64]);
    exp_rd[cyc % 64] = 1'b0;
    exp_wr[cyc % 64] = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    int r;
    r = $urandom(32'd2024);
    rst_n = 0; cmd_vld = 0; cmd_is_wr = 0; cmd_bl8 = 0;
    setcfg(5, 5, 0);
    repeat (4) @(negedge clk);
    rst_n = 1;
    check("R1 rd_win", rd_win, 1'b0);
    check("R1 wr_win", wr_win, 1'b0);
    idle(2);

    ph = "R2 shortest read BL8";
    setcfg(5, 5, 0); step(1, 0, 1); idle(12);
    ph = "R3 R4 write AL=CL-1 BL4";
    setcfg(7, 5, 1); step(1, 1, 0); idle(16);
    ph = "R4 read AL=CL-2 CL=11";
    setcfg(11, 8, 2); step(1, 0, 1); idle(26);
    ph = "R4 write AL=CL-1 CWL=8";
    setcfg(11, 8, 1); step(1, 1, 1); idle(24);

    ph = "R7 change while pending";
    setcfg(5, 5, 0); step(1, 0, 1);
    setcfg(11, 8, 2); idle(3);
    step(1, 0, 1); step(0, 0, 0);
    setcfg(6, 6, 0); idle(14);
    step(1, 0, 0); idle(12);

    ph = "R8 reserved code";
    setcfg(6, 6, 3); step(1, 0, 1); idle(14);
    ph = "R8 CL out of range";
    setcfg(4, 5, 0); step(1, 1, 1); idle(14);
    setcfg(12, 5, 0); step(1, 0, 1); idle(3);
    setcfg(6, 9, 0); step(1, 1, 0); idle(14);

    ph = "R6 back-to-back reads";
    setcfg(5, 5, 0);
    for (int i = 0; i < 5; i++) begin step(1, 0, 1); idle(3); end
    idle(14);
    ph = "R6 R9 reads overlapping writes";
    setcfg(8, 5, 0);
    for (int i = 0; i < 6; i++) begin step(1, i[0], 1); idle(3); end
    idle(20);

    ph = "R6 random";
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 2) == 0) begin
        if ($urandom_range(0, 9) == 0)
          setcfg($urandom_range(5, 11), $urandom_range(5, 8), 3);
        else
          setcfg($urandom_range(5, 11), $urandom_range(5, 8), $urandom_range(0, 2));
      end
      step(1, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      for (int k = 0; k < 3 + int'($urandom_range(0, 5)); k++) begin
        if ($urandom_range(0, 7) == 0)
          setcfg($urandom_range(5, 11), $urandom_range(5, 8), $urandom_range(0, 2));
        step(0, 0, 0);
      end
    end
    idle(30);
    finish_run();
  end
endmodule